// File: doc/BRIEF.md
# Colour Lookup RAM with Vertical-Blank Access Arbitration

This block holds a 256-entry colour table that converts an 8-bit pixel index into a 32-bit xRGB colour word. The display pixel path reads it on every pixel. A CPU register port may also write it, but only after it has been granted access. The word layout keeps red in bits 23:16, green in 15:8 and blue in 7:0. Bits 31:24 are always stored as zero.

Software sets a request bit in a small control register and polls a grant bit in the same register. The grant is issued only at a vertical-blanking start pulse. While access is granted, the lookup pipeline is frozen, so the panel keeps receiving the last colour it was given. Software then writes entries through a byte-addressed window and clears the request. Every stored word is trimmed to 5 bits of red, 6 of green and 5 of blue.

A rising edge on the secondary display enable fills the whole table with scrambled values. For that reason the table has to be loaded after that enable has been raised.

Top module: `palette_ram_arbiter`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0, `color_valid` is 0 and `color_out` is 0.
- R2: A control write stores `ctrl_wdata[0]` as the request, and the request reads back in `ctrl_rdata[0]` after that clock edge. While the request is held, the grant in `ctrl_rdata[4]` rises on the edge that samples `vblank_start` high, and not before it.
- R3: A `vblank_start` pulse produces no grant when no request is stored. This includes a request written in the same cycle as the pulse.
- R4: A control write with bit 0 clear drops the request at that edge, and the grant falls at the following edge. Readback is 0x0010 after the first of these edges and 0x0000 after the second.
- R5: A palette write made while access is granted stores `pal_wdata & 0x00F8FCF8` at entry `pal_byte_addr[9:2]`. Bits 1:0 of the address are ignored.
- R6: A palette write made without a grant changes no entry. This holds both with no request stored and with a request that has not yet been granted.
- R7: A pixel index presented with `pix_valid` at clock edge k produces that entry's colour on `color_out`, with `color_valid` high, after edge k+1.
- R8: While access is granted, `color_out` and `color_valid` hold their values whatever the pixel inputs do. Lookup resumes once the grant has fallen.
- R9: A rising edge of `disp_en2` overwrites every entry with a trimmed scramble value. Entry 0 then has a nonzero green field. Granted writes made afterwards take effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| disp_en2 | input | 1 | Secondary display enable; its rising edge scrambles the table |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write data; bit 0 is the request |
| ctrl_rdata | output | 16 | Control readback; bit 0 is the request, bit 4 is the grant |
| pal_wr | input | 1 | Palette write strobe |
| pal_byte_addr | input | 10 | Palette byte offset; entry n sits at 4n |
| pal_wdata | input | 32 | Palette write data in xRGB layout |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | 8 | Pixel colour index |
| color_valid | output | 1 | Output colour valid |
| color_out | output | 32 | Looked-up xRGB colour |

## Verification
The results are due at different delays after their stimulus:
- Control readback reflects a write one edge after it.
- The grant appears at the edge that samples the blanking pulse.
- The grant falls one edge after the request drops.
- A pixel colour appears two edges after its index.

The bench drives every input on a falling edge and samples exactly that many rising edges later, again at a falling edge. It sweeps all 256 entries with an arithmetic pattern, computing the trimmed value field by field. During the frozen window it presents a different index, so a pipeline that failed to stall would show the new colour.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int          PAL_IDX_W  = 8;
  localparam int          PAL_DATA_W = 32;
  localparam logic [31:0] COLOR_KEEP = 32'h00F8FCF8;
  localparam int          REQ_BIT    = 0;
  localparam int          GRANT_BIT  = 4;

  // Keep only the implemented colour bits.
  function automatic logic [31:0] trim_color(input logic [31:0] raw);
    return raw & COLOR_KEEP;
  endfunction

  // Garbage pattern written by the enable edge; green uses ~slot so entry 0 is nonzero.
  function automatic logic [31:0] noise_word(input logic [7:0] slot, input logic [7:0] seed);
    return trim_color({8'h00, slot ^ seed, ~slot, slot + seed});
  endfunction

  // Byte offset to entry number (word addressed).
  function automatic logic [7:0] entry_of(input logic [9:0] byte_addr);
    return byte_addr[9:2];
  endfunction
endpackage

// File: rtl/pal_access_ctrl.sv
module pal_access_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        req_in,
  input  logic        vblank_start,
  output logic        req_o,
  output logic        grant_o
);
  logic req_q, grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      if (ctrl_wr) req_q <= req_in;
      // grant only opens at blanking start, and closes one edge after request drops
      grant_q <= req_q & (grant_q | vblank_start);
    end
  end

  assign req_o   = req_q;
  assign grant_o = grant_q;
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = pal_pkg::PAL_IDX_W,
  parameter int DATA_W = pal_pkg::PAL_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              grant,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en2,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  import pal_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              en2_q;
  logic [7:0]        seed_q;
  logic              scramble_now;
  logic              wr_fire;

  assign scramble_now = en2 & ~en2_q;
  assign wr_fire      = wr_req & grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en2_q  <= 1'b0;
      seed_q <= 8'h3C;
    end else begin
      en2_q  <= en2;
      seed_q <= seed_q + 8'd37;
    end
  end

  always_ff @(posedge clk) begin
    if (scramble_now) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= DATA_W'(noise_word(8'(i), seed_q));
    end else if (wr_fire) begin
      mem[wr_idx] <= DATA_W'(trim_color(32'(wr_data)));
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pal_lookup_pipe.sv
module pal_lookup_pipe #(
  parameter int IDX_W  = pal_pkg::PAL_IDX_W,
  parameter int DATA_W = pal_pkg::PAL_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_color
);
  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_idx    <= '0;
      out_valid <= 1'b0;
      out_color <= '0;
    end else if (!stall) begin
      s1_valid  <= pix_valid;
      s1_idx    <= pix_idx;
      out_valid <= s1_valid;
      out_color <= rd_data;
    end
  end

  assign rd_idx = s1_idx;
endmodule

// File: rtl/palette_ram_arbiter.sv
module palette_ram_arbiter #(
  parameter int IDX_W  = pal_pkg::PAL_IDX_W,
  parameter int DATA_W = pal_pkg::PAL_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_start,
  input  logic              disp_en2,
  input  logic              ctrl_wr,
  input  logic [15:0]       ctrl_wdata,
  output logic [15:0]       ctrl_rdata,
  input  logic              pal_wr,
  input  logic [IDX_W+1:0]  pal_byte_addr,
  input  logic [DATA_W-1:0] pal_wdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              color_valid,
  output logic [DATA_W-1:0] color_out
);
  import pal_pkg::*;

  logic              req;
  logic              grant;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;

  pal_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .req_in(ctrl_wdata[REQ_BIT]),
    .vblank_start(vblank_start), .req_o(req), .grant_o(grant)
  );

  pal_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(pal_wr), .grant(grant),
    .wr_idx(pal_byte_addr[IDX_W+1:2]), .wr_data(pal_wdata), .en2(disp_en2),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  pal_lookup_pipe #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .stall(grant), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_valid(color_valid), .out_color(color_out)
  );

  always_comb begin
    ctrl_rdata            = '0;
    ctrl_rdata[REQ_BIT]   = req;
    ctrl_rdata[GRANT_BIT] = grant;
  end
endmodule

// File: rtl/palette_ram_arbiter_chk.sv
module palette_ram_arbiter_chk #(
  parameter int DATA_W = pal_pkg::PAL_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              grant,
  input logic              vblank_start,
  input logic              color_valid,
  input logic [DATA_W-1:0] color_out
);
  import pal_pkg::*;

  p_grant_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(req) && $past(vblank_start)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> ($stable(color_out) && $stable(color_valid)));

  p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    color_valid |-> ((32'(color_out) & ~COLOR_KEEP) == 32'h0));
endmodule

bind palette_ram_arbiter palette_ram_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .vblank_start(vblank_start),
  .color_valid(color_valid), .color_out(color_out)
);

// File: tb/tb_palette_ram_arbiter.sv
module tb_palette_ram_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vblank_start = 1'b0;
  logic        disp_en2 = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        pal_wr = 1'b0;
  logic [9:0]  pal_byte_addr = '0;
  logic [31:0] pal_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        color_valid;
  logic [31:0] color_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  palette_ram_arbiter dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] raw_pat(input int i);
    logic [7:0] b = 8'(i);
    return {8'hC3, b ^ 8'h5A, 8'(b * 3), ~b};
  endfunction

  // independent restatement of the trim: red top5, green top6, blue top5, x byte zero
  function automatic logic [31:0] trimmed(input logic [31:0] w);
    return {8'h00, w[23:19], 3'b000, w[15:10], 2'b00, w[7:3], 3'b000};
  endfunction

  task automatic ctrl_write(input logic [15:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank_start = 1'b1;
    @(negedge clk); vblank_start = 1'b0;
  endtask

  task automatic pal_write(input int idx, input logic [1:0] lo, input logic [31:0] d);
    @(negedge clk); pal_wr = 1'b1; pal_byte_addr = {8'(idx), lo}; pal_wdata = d;
    @(negedge clk); pal_wr = 1'b0;
  endtask

  task automatic lookup(input int idx, output logic [31:0] c, output logic v);
    @(negedge clk); pix_valid = 1'b1; pix_idx = 8'(idx);
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk); c = color_out; v = color_valid;
  endtask

  task automatic acquire();
    ctrl_write(16'h0001);
    pulse_vb();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    logic v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 16'h0, "R1 rdata", 32'(ctrl_rdata), 32'h0);
    chk(color_valid == 1'b0, "R1 valid", 32'(color_valid), 32'h0);
    chk(color_out == 32'h0, "R1 color", color_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 blanking pulse without request
    pulse_vb();
    chk(ctrl_rdata == 16'h0000, "R3 no req", 32'(ctrl_rdata), 32'h0);
    // R3 request written in same cycle as pulse
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 16'h0001; vblank_start = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0; vblank_start = 1'b0;
    chk(ctrl_rdata == 16'h0001, "R3 same cycle", 32'(ctrl_rdata), 32'h1);
    // R6 write while requested but not granted
    pal_write(8, 2'b00, 32'hFFFFFFFF);
    // R2 grant on blanking pulse
    pulse_vb();
    chk(ctrl_rdata == 16'h0011, "R2 grant", 32'(ctrl_rdata), 32'h11);
    ctrl_write(16'h0000);
    @(negedge clk);

    // R9 raise the secondary enable before loading
    @(negedge clk); disp_en2 = 1'b1;
    @(negedge clk);

    // R5 load all entries with varied low address bits
    acquire();
    for (int i = 0; i < 256; i++) pal_write(i, 2'(i), raw_pat(i));
    ctrl_write(16'h0000);
    chk(ctrl_rdata == 16'h0010, "R4 first edge", 32'(ctrl_rdata), 32'h10);
    @(negedge clk);
    chk(ctrl_rdata == 16'h0000, "R4 second edge", 32'(ctrl_rdata), 32'h0);

    // R7 / R5 sweep every entry
    for (int i = 0; i < 256; i++) begin
      lookup(i, c, v);
      chk(v && c == trimmed(raw_pat(i)), "R7 R5 sweep", c, trimmed(raw_pat(i)));
    end

    // R6 ungranted writes leave entries untouched
    pal_write(7, 2'b00, 32'h00000000);
    lookup(7, c, v);
    chk(c == trimmed(raw_pat(7)), "R6 no req", c, trimmed(raw_pat(7)));
    lookup(8, c, v);
    chk(c == trimmed(raw_pat(8)), "R6 req not granted", c, trimmed(raw_pat(8)));

    // R8 output frozen while granted
    @(negedge clk); pix_valid = 1'b1; pix_idx = 8'd1;
    repeat (3) @(negedge clk);
    chk(color_out == trimmed(raw_pat(1)), "R7 stream", color_out, trimmed(raw_pat(1)));
    acquire();
    pix_idx = 8'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(color_valid && color_out == trimmed(raw_pat(1)), "R8 hold", color_out, trimmed(raw_pat(1)));
    end
    ctrl_write(16'h0000);
    repeat (4) @(negedge clk);
    chk(color_out == trimmed(raw_pat(2)), "R8 resume", color_out, trimmed(raw_pat(2)));
    pix_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R9 re-raising the enable scrambles the table
    @(negedge clk); disp_en2 = 1'b0;
    @(negedge clk); disp_en2 = 1'b1;
    @(negedge clk);
    lookup(0, c, v);
    chk(c[15:8] != 8'h00, "R9 scrambled green", c, 32'h0000FC00);
    chk((c & 32'hFF070307) == 32'h0, "R9 scramble trimmed", c & 32'hFF070307, 32'h0);
    acquire();
    pal_write(0, 2'b11, 32'h12345678);
    ctrl_write(16'h0000);
    @(negedge clk);
    lookup(0, c, v);
    chk(c == trimmed(32'h12345678), "R9 reload", c, trimmed(32'h12345678));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule